// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of a read or write burst inside a synchronous DRAM. When the command decoder accepts a read or write, it pulses `cmd_start` together with the starting column, a burst-length code and an ordering bit. The block registers these values. From the next cycle on, it presents one column per clock on `col_out` and raises `beat_valid` for each beat.

Two orderings are supported. Sequential order counts up inside the aligned burst window and wraps within it. Interleaved order XORs the beat number into the low bits of the start column. A full-page burst walks through every column of the row, wraps from the top column to zero, and runs until it is cut off. A terminate pulse ends any burst. A new read or write command restarts address generation from its own start column on any cycle. `beat_last` marks the final beat of a fixed-length burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and on the first cycle after it, `beat_valid` and `beat_last` are 0.
- R2: When `cmd_start` is 1 at a rising edge, then in the following cycle `beat_valid` is 1 and `col_out` equals the `start_col` sampled at that edge. `cfg_len` and `cfg_order` are captured at the same edge.
- R3: `cfg_len` encodes the burst length: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page. The codes 3'b100 to 3'b110 behave as a 1-beat burst.
- R4: With `cfg_order` = 0 (sequential) and a fixed length BL, beat n has low log2(BL) bits equal to (start + n) mod BL. The upper column bits equal those of the start column.
- R5: With `cfg_order` = 1 (interleaved) and a fixed length BL, beat n has low log2(BL) bits equal to the start column's low bits XOR n. The upper bits are unchanged.
- R6: A full-page burst presents start, start+1, ... modulo 2^COL_W (2048 columns by default). It continues without limit and never raises `beat_last`.
- R7: The full-page code with `cfg_order` = 1 runs as a sequential full-page burst.
- R8: `beat_last` is 1 exactly on the final beat of a fixed-length burst. If no new command arrives, `beat_valid` is 0 in the next cycle.
- R9: When `cmd_stop` is 1 at an edge and `cmd_start` is 0, `beat_valid` is 0 from the next cycle on.
- R10: `cmd_start` during a burst in progress replaces that burst: the next cycle shows beat 0 of the new burst. `cmd_start` wins over a simultaneous `cmd_stop`.
- R11: While idle, with no `cmd_start`, `beat_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Read or write command accepted this cycle |
| start_col | input | COL_W | Start column of the new burst |
| cfg_len | input | 3 | Burst length code |
| cfg_order | input | 1 | 0 = sequential, 1 = interleaved |
| cmd_stop | input | 1 | Burst terminate accepted this cycle |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bound checker enforces the following on every cycle:
- the first beat after each command equals the sampled start column;
- terminate removes the beat stream, and a burst never begins without a command;
- the last flag only appears on valid beats, is absent in full page and drops the stream after it;
- the upper column bits hold still in fixed bursts, and full-page bursts step by exactly one.

Only the directed scenarios can show the actual beat order:
- the wrap position in sequential mode and the XOR pattern in interleaved mode;
- the fallback for reserved length codes and for interleaved full page;
- restart mid-burst with its priority over terminate.

// File: rtl/colgen_pkg.sv
// Shared encodings for the burst column generator.
package colgen_pkg;
    // Burst length codes; values not listed act as a single beat.
    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_FULL = 3'b111
    } burst_len_e;

    // Beat ordering within a fixed-length burst.
    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } burst_ord_e;
endpackage

// File: rtl/colgen_cfg_decode.sv
// Turns a latched length code and ordering bit into a wrap mask, a
// full-page flag and the ordering actually applied.
// Assumes COL_W >= 3 so that an 8-beat window fits in the column.
module colgen_cfg_decode
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [2:0]       len_code,
    input  logic             order_in,
    output logic [COL_W-1:0] wrap_mask,
    output logic             full_page,
    output logic             use_intlv
);
    // Map the code to the mask of column bits that change during the burst.
    always_comb begin
        full_page = (len_code == LEN_FULL);
        case (len_code)
            LEN_2:    wrap_mask = COL_W'(1);
            LEN_4:    wrap_mask = COL_W'(3);
            LEN_8:    wrap_mask = COL_W'(7);
            LEN_FULL: wrap_mask = '1;
            default:  wrap_mask = '0;
        endcase
        // Interleaving is defined only for fixed lengths; full page counts up.
        use_intlv = (order_in == ORD_INTLV) && !full_page;
    end
endmodule

// File: rtl/colgen_beat_ctrl.sv
// Tracks whether a burst is running and the index of the current beat.
// Assumes start has priority over stop. A fixed burst ends by itself
// after its final beat, and a full-page burst runs until stopped.
module colgen_beat_ctrl #(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             full_page,
    output logic             active,
    output logic [COL_W-1:0] beat_idx,
    output logic             final_beat
);
    // Flag the final beat of a fixed-length burst.
    always_comb begin
        final_beat = active && !full_page && (beat_idx == wrap_mask);
    end

    // Advance, restart or end the burst once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat_idx <= '0;
        end else if (start) begin
            active   <= 1'b1;
            beat_idx <= '0;
        end else if (stop || final_beat) begin
            active   <= 1'b0;
            beat_idx <= '0;
        end else if (active) begin
            beat_idx <= beat_idx + COL_W'(1);
        end
    end
endmodule

// File: rtl/colgen_addr_map.sv
// Combines the start column and the beat index into the column of the
// current beat. Bits inside the wrap mask take either the sum or the XOR;
// bits outside keep the start column's value.
module colgen_addr_map #(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             use_intlv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum_col;

    // Running sum; carries past the mask are discarded bit by bit below.
    always_comb begin
        sum_col = base_col + beat_idx;
    end

    // One selector per column bit.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!wrap_mask[i])
                col[i] = base_col[i];
            else if (use_intlv)
                col[i] = base_col[i] ^ beat_idx[i];
            else
                col[i] = sum_col[i];
        end
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
// Burst column address generator. Captures the start column and burst
// configuration on cmd_start. From the next cycle on, it presents one
// column per clock until the burst completes, is terminated or is replaced.
// Assumes cmd_start and cmd_stop come from an already decoded command.
module sdram_burst_colgen #(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_order,
    input  logic             cmd_stop,
    output logic [COL_W-1:0] col_out,
    output logic             beat_valid,
    output logic             beat_last
);
    logic [COL_W-1:0] base_q;
    logic [2:0]       len_q;
    logic             ord_q;
    logic [COL_W-1:0] wrap_mask;
    logic             cfg_full;
    logic             use_intlv;
    logic             active;
    logic [COL_W-1:0] beat_idx;
    logic             final_beat;

    // Hold the burst parameters for the life of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= 3'b000;
            ord_q  <= 1'b0;
        end else if (cmd_start) begin
            base_q <= start_col;
            len_q  <= cfg_len;
            ord_q  <= cfg_order;
        end
    end

    colgen_cfg_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_q),
        .order_in  (ord_q),
        .wrap_mask (wrap_mask),
        .full_page (cfg_full),
        .use_intlv (use_intlv)
    );

    colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_start),
        .stop       (cmd_stop),
        .wrap_mask  (wrap_mask),
        .full_page  (cfg_full),
        .active     (active),
        .beat_idx   (beat_idx),
        .final_beat (final_beat)
    );

    colgen_addr_map #(.COL_W(COL_W)) u_map (
        .base_col  (base_q),
        .beat_idx  (beat_idx),
        .wrap_mask (wrap_mask),
        .use_intlv (use_intlv),
        .col       (col_out)
    );

    // Drive the beat flags from the controller state.
    always_comb begin
        beat_valid = active;
        beat_last  = final_beat;
    end
endmodule

// File: rtl/colgen_checker.sv
// Cycle-by-cycle properties of the burst column generator, bound to the top.
// full_q is the latched full-page flag taken from inside the top.
module colgen_checker #(
    parameter int COL_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             beat_last,
    input logic             full_q
);
    // R2 / R10: the cycle after a command shows its start column.
    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (beat_valid && col_out == $past(start_col)));

    // R9: terminate without a new command ends the beat stream.
    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !beat_valid);

    // R11: no burst starts without a command.
    assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && !cmd_start) |=> !beat_valid);

    // R8: the last flag only accompanies a valid beat.
    assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R8: after the last beat, the stream drops unless restarted.
    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !cmd_start) |=> !beat_valid);

    // R6: a full-page burst never flags a last beat.
    assert_full_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && full_q) |-> !beat_last);

    // R6: a full-page burst steps by one column, wrapping at the top.
    assert_full_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && full_q && !cmd_start && !cmd_stop) |=>
            (beat_valid && col_out == $past(col_out) + COL_W'(1)));

    // R4 / R5: a fixed burst never touches column bits above the 8-beat window.
    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !full_q && !beat_last && !cmd_start && !cmd_stop) |=>
            (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .start_col  (start_col),
    .col_out    (col_out),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .full_q     (cfg_full)
);

// File: tb/sdram_burst_colgen_tb.sv
// Directed bench: one task per scenario, each checking its own beats.
module sdram_burst_colgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 11;
    localparam int NCOL       = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       cfg_len = 3'b000;
    logic             cfg_order = 1'b0;
    logic             cmd_stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             beat_valid;
    logic             beat_last;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .start_col  (start_col),
        .cfg_len    (cfg_len),
        .cfg_order  (cfg_order),
        .cmd_stop   (cmd_stop),
        .col_out    (col_out),
        .beat_valid (beat_valid),
        .beat_last  (beat_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected column of beat n; bl = 0 means full page.
    function automatic int exp_col(int s, int n, int bl, bit ord);
        int base, off;
        if (bl == 0) return (s + n) % NCOL;
        base = s - (s % bl);
        off  = s % bl;
        if (ord) return base + (off ^ n);
        return base + ((off + n) % bl);
    endfunction

    // Present a command for one cycle; returns at the negedge where beat 0 shows.
    task automatic issue(input int col, input int code, input bit ord, input bit with_stop);
        cmd_start = 1'b1;
        start_col = COL_W'(col);
        cfg_len   = 3'(code);
        cfg_order = ord;
        cmd_stop  = with_stop;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
    endtask

    // Check beats 0..cnt-1 packed as {valid, last, col}; bl = 0 is full page.
    task automatic expect_beats(input string req, input int s, input int cnt,
                                input int bl, input bit ord, input bit end_after);
        for (int n = 0; n < cnt; n++) begin
            int lst;
            lst = (bl != 0 && n == bl - 1) ? 1 : 0;
            chk(req, {beat_valid, beat_last, col_out},
                {1'b1, lst[0], COL_W'(exp_col(s, n, bl, ord))});
            @(negedge clk);
        end
        if (end_after) chk({req, " end"}, {beat_valid, beat_last}, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset valid/last", {beat_valid, beat_last}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {beat_valid, beat_last}, 0);
        repeat (3) @(negedge clk);
        chk("R11 idle", {beat_valid, beat_last}, 0);
    endtask

    task automatic t_seq();
        issue(6, 3'b010, 1'b0, 1'b0);
        expect_beats("R4 R8 seq BL4", 6, 4, 4, 1'b0, 1'b1);
        issue(13, 3'b011, 1'b0, 1'b0);
        expect_beats("R4 R8 seq BL8", 13, 8, 8, 1'b0, 1'b1);
        issue(3, 3'b001, 1'b0, 1'b0);
        expect_beats("R3 R4 seq BL2", 3, 2, 2, 1'b0, 1'b1);
        issue(3, 3'b000, 1'b0, 1'b0);
        expect_beats("R3 R2 BL1", 3, 1, 1, 1'b0, 1'b1);
    endtask

    task automatic t_intlv();
        issue(5, 3'b011, 1'b1, 1'b0);
        expect_beats("R5 intlv BL8", 5, 8, 8, 1'b1, 1'b1);
        issue(12'h102, 3'b010, 1'b1, 1'b0);
        expect_beats("R5 intlv BL4", 12'h102, 4, 4, 1'b1, 1'b1);
    endtask

    task automatic t_reserved();
        issue(77, 3'b101, 1'b0, 1'b0);
        expect_beats("R3 reserved code", 77, 1, 1, 1'b0, 1'b1);
    endtask

    task automatic t_full();
        issue(NCOL - 3, 3'b111, 1'b0, 1'b0);
        expect_beats("R6 full page wrap", NCOL - 3, 12, 0, 1'b0, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop full page", {beat_valid, beat_last}, 0);
        issue(10, 3'b111, 1'b1, 1'b0);
        expect_beats("R7 intlv full runs seq", 10, 9, 0, 1'b0, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop R7 burst", {beat_valid, beat_last}, 0);
    endtask

    task automatic t_terminate();
        issue(40, 3'b011, 1'b0, 1'b0);
        expect_beats("R9 before stop", 40, 3, 8, 1'b0, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R9 stop mid burst", {beat_valid, beat_last}, 0);
        repeat (2) @(negedge clk);
        chk("R11 idle after stop", {beat_valid, beat_last}, 0);
    endtask

    task automatic t_restart();
        issue(0, 3'b011, 1'b0, 1'b0);
        expect_beats("R10 first burst", 0, 2, 8, 1'b0, 1'b0);
        issue(12'h065, 3'b010, 1'b1, 1'b0);
        expect_beats("R10 restart", 12'h065, 4, 4, 1'b1, 1'b1);
        issue(200, 3'b011, 1'b0, 1'b0);
        expect_beats("R10 pre-collision", 200, 1, 8, 1'b0, 1'b0);
        issue(300, 3'b001, 1'b0, 1'b1);
        expect_beats("R10 start beats stop", 300, 2, 2, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_seq();
        t_intlv();
        t_reserved();
        t_full();
        t_terminate();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule